// File: doc/BRIEF.md
# Frequency Acquisition Controller

This block steers a controllable oscillator close to its target rate before a clock-recovery loop takes over. After reset it opens an acquisition window that lasts a fixed number of reference-clock cycles. While the window is open, the main phase-locked loop is held off and the far end sends an alternating 0/1 training pattern. A signed up/down accumulator compares two edge rates: every data transition raises the count by one, and every rising edge of the oscillator clock divided by two lowers it by one. The accumulator value is the code for an external current DAC that biases the oscillator. The loop is first order, and the accumulator is its only filter. It settles when the oscillator runs at twice the data rate.

When the window closes, the code freezes, the main-loop enable rises and a done flag is raised. Both stay that way until the next reset. The data input and the divided oscillator clock are synchronised into the reference-clock domain, and edge detection and accumulation happen there. The ports carry control levels and the DAC code, with no stream handshake: the code is a level that the DAC reads at any time.

Top module: `freq_acq_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `dac_code` is mid-scale (16 for a 5-bit code), and `pll_en` and `acq_done` are 0.
- R2: `acq_done` goes to 1 exactly after `WINDOW_CYC` rising edges of `ref_clk` following the release of reset. It stays 1 until the next reset, and `pll_en` always equals `acq_done`.
- R3: While the window is open, each transition of `data_in`, rising or falling, raises `dac_code` by one, SYNC_STAGES+1 reference cycles after the transition.
- R4: `osc_clk` is divided by two, starting from low at reset. Only rising edges of the divided clock lower `dac_code` by one. Of successive `osc_clk` rising edges, the 1st, 3rd, 5th and so on count.
- R5: `dac_code` saturates at its maximum (31): an increment there has no effect.
- R6: `dac_code` saturates at 0: a decrement there has no effect.
- R7: An increment and a decrement that arrive in the same reference cycle cancel, even when the code sits at a rail.
- R8: When the oscillator runs at exactly twice the toggle rate of an alternating data pattern, the code stays put. At three times that rate, the code drops by the excess divided edges.
- R9: After the window closes, `dac_code` is frozen: transitions on `data_in` or `osc_clk` do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the timer, synchronisers and accumulator |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| osc_clk | input | 1 | Clock from the controlled oscillator |
| data_in | input | 1 | Received data stream (training pattern during acquisition) |
| dac_code | output | CODE_W | Current-DAC code; the accumulator value |
| pll_en | output | 1 | Enable for the main phase-locked loop |
| acq_done | output | 1 | Acquisition window has closed |

## Verification
The assertions check, on every reference cycle, the local step rules of the accumulator. These are a one-step rise on a lone increment, holding at a rail, holding when increment and decrement coincide, and holding once the window is closed. They also check that the done flag never falls. Only the bench scenarios can show the end-to-end results. These cover how many counted edges a given oscillator or data pattern produces through the divider and the synchronisers, that balance occurs at twice the data toggle rate, and that the window closes at the exact cycle count. Each scenario's final code is predicted from event counts and compared when the window closes.

// File: rtl/fac_pkg.sv
package fac_pkg;
  // Default width of the DAC code and accumulator.
  localparam int unsigned CODE_W_DEF = 5;

  // Mid-scale start value for a code of width w.
  function automatic int unsigned mid_code(input int unsigned w);
    return 1 << (w - 1);
  endfunction

  // Full-scale value for a code of width w.
  function automatic int unsigned max_code(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/fac_sync.sv
// Multi-flop synchroniser into the clk domain, reset low.
module fac_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic chain [0:STAGES];

  assign chain[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i+1] <= 1'b0;
      else        chain[i+1] <= chain[i];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/fac_osc_div.sv
// Divide-by-two of the oscillator clock, in the oscillator domain.
module fac_osc_div (
  input  logic osc_clk,
  input  logic rst_n,
  output logic half_o
);
  logic half_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign half_o = half_q;
endmodule

// File: rtl/fac_edge_det.sv
// Single-cycle pulse on a change of a synchronised level.
// ANY_EDGE=1 flags both directions, ANY_EDGE=0 flags rising only.
module fac_edge_det #(
  parameter bit ANY_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  if (ANY_EDGE) begin : g_both
    assign pulse = lvl ^ lvl_prev;
  end else begin : g_rise
    assign pulse = lvl & ~lvl_prev;
  end
endmodule

// File: rtl/fac_window_timer.sv
// Post-reset acquisition window of WINDOW_CYC reference cycles.
module fac_window_timer #(
  parameter int unsigned WINDOW_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic acq_on,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign acq_on = (cnt != LAST);
  assign done   = ~acq_on;

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/fac_accum.sv
// Saturating up/down accumulator acting as the loop filter.
module fac_accum #(
  parameter int unsigned CODE_W = fac_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_on,
  input  logic              inc,
  input  logic              dec,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(fac_pkg::mid_code(CODE_W));
  localparam logic [CODE_W-1:0] TOP = CODE_W'(fac_pkg::max_code(CODE_W));

  logic [CODE_W-1:0] acc_q;
  logic              up_ok;
  logic              dn_ok;

  always_comb begin
    up_ok = acq_on & inc & ~dec & (acc_q != TOP);
    dn_ok = acq_on & dec & ~inc & (acc_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= MID;
    else if (up_ok) acc_q <= acc_q + 1'b1;
    else if (dn_ok) acc_q <= acc_q - 1'b1;
  end

  assign code = acc_q;

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_on && inc && !dec && code != TOP) |=> code == $past(code) + CODE_W'(1));
  // R5
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_on && inc && !dec && code == TOP) |=> code == TOP);
  // R6
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_on && dec && !inc && code == '0) |=> code == '0);
  // R7
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(code));
  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_on |=> $stable(code));
endmodule

// File: rtl/freq_acq_ctrl.sv
module freq_acq_ctrl #(
  parameter int unsigned CODE_W      = fac_pkg::CODE_W_DEF,
  parameter int unsigned WINDOW_CYC  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              osc_clk,
  input  logic              data_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              pll_en,
  output logic              acq_done
);
  logic osc_half;
  logic osc_half_s;
  logic data_s;
  logic data_evt;
  logic osc_evt;
  logic acq_on;
  logic win_done;

  fac_osc_div u_div (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .half_o  (osc_half)
  );

  fac_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (osc_half),
    .q     (osc_half_s)
  );

  fac_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (data_in),
    .q     (data_s)
  );

  fac_edge_det #(.ANY_EDGE(1'b1)) u_edge_data (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .lvl   (data_s),
    .pulse (data_evt)
  );

  fac_edge_det #(.ANY_EDGE(1'b0)) u_edge_osc (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .lvl   (osc_half_s),
    .pulse (osc_evt)
  );

  fac_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .acq_on (acq_on),
    .done   (win_done)
  );

  fac_accum #(.CODE_W(CODE_W)) u_acc (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .acq_on (acq_on),
    .inc    (data_evt),
    .dec    (osc_evt),
    .code   (dac_code)
  );

  assign pll_en   = win_done;
  assign acq_done = win_done;

  // R2
  pll_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    acq_on |-> !pll_en);
endmodule

// File: tb/sim_freq_acq_ctrl.sv
module sim_freq_acq_ctrl;
  localparam int WIN = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0;
  logic       data = 1'b0;
  logic [4:0] code;
  logic       pll_en;
  logic       done;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  string req_q[$];
  bit done_q = 1'b0;

  freq_acq_ctrl #(.CODE_W(5), .WINDOW_CYC(WIN), .SYNC_STAGES(2)) u0 (
    .ref_clk (clk),
    .rst_n   (rst_n),
    .osc_clk (osc),
    .data_in (data),
    .dac_code(code),
    .pll_en  (pll_en),
    .acq_done(done)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: when the window closes, pop the expected final code.
  initial begin
    forever begin
      @(negedge clk);
      if (done && !done_q) begin
        if (exp_q.size() == 0) chk("R2 unexpected window close", 1, 0);
        else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(r, int'(code), e);
        end
      end
      done_q = done;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    data  = 1'b0;
    osc   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", int'(code), 16);
    chk("R1 pll_en in reset", int'(pll_en), 0);
    rst_n = 1'b1;
  endtask

  task automatic toggle_data(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data = ~data;
      @(negedge clk);
    end
  endtask

  task automatic osc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc = 1'b1;
      @(negedge clk); osc = 1'b0;
    end
  endtask

  // One bit of training pattern with `per` oscillator periods per bit;
  // the data transition coincides with the first oscillator rise.
  task automatic train_bits(input int bits, input int per);
    for (int b = 0; b < bits; b++) begin
      for (int p = 0; p < per; p++) begin
        @(negedge clk);
        if (p == 0) data = ~data;
        osc = 1'b1;
        @(negedge clk); osc = 1'b0;
      end
    end
  endtask

  task automatic expect_final(input int e, input string r);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic wait_close();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 / R2: idle window, exact close timing
    do_reset();
    chk("R1 done after release", int'(done), 0);
    chk("R1 code after release", int'(code), 16);
    expect_final(16, "R1 idle window keeps mid-scale");
    repeat (WIN - 1) @(negedge clk);
    chk("R2 done before last cycle", int'(done), 0);
    chk("R2 pll_en before last cycle", int'(pll_en), 0);
    @(negedge clk);
    chk("R2 done at window end", int'(done), 1);
    chk("R2 pll_en at window end", int'(pll_en), 1);
    repeat (20) @(negedge clk);
    chk("R2 done stays high", int'(done), 1);

    // R3 then R9: five data edges, then activity after close
    do_reset();
    toggle_data(5);
    expect_final(21, "R3 five data edges");
    wait_close();
    toggle_data(6);
    osc_pulses(9);
    repeat (5) @(negedge clk);
    chk("R9 code frozen after close", int'(code), 21);
    chk("R9 pll_en after close", int'(pll_en), 1);

    // R5: upper rail
    do_reset();
    toggle_data(20);
    expect_final(31, "R5 saturate at top");
    wait_close();

    // R6: lower rail
    do_reset();
    osc_pulses(40);
    expect_final(0, "R6 saturate at zero");
    wait_close();

    // R4: three oscillator rises give two divided rises
    do_reset();
    osc_pulses(3);
    expect_final(14, "R4 divide-by-two odd rises");
    wait_close();

    // R8: oscillator at twice the data toggle rate
    do_reset();
    train_bits(10, 2);
    expect_final(16, "R8 balance at twice data rate");
    wait_close();

    // R8: oscillator at three times the data toggle rate, 8 bits
    do_reset();
    train_bits(8, 3);
    expect_final(12, "R8 excess at three times data rate");
    wait_close();

    // R7: coincident inc and dec at the upper rail
    do_reset();
    toggle_data(20);
    train_bits(3, 2);
    expect_final(31, "R7 cancel at top rail");
    wait_close();

    repeat (4) @(negedge clk);
    chk("R2 every window closed", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule